// File: doc/BRIEF.md
# DVMA Page Table Translation Engine

This block turns one device DMA request into a series of physical access commands. A request gives a device virtual address, a byte count and a direction. The engine cuts the transfer at 4 KB page boundaries. For each page it computes where the page-table entry sits, using a table base value and a programmable window size. It reads the 32-bit entry over a memory read port, checks the entry's permission bits, and issues a command that carries the 36-bit physical address, the chunk length and the direction. The engine only produces commands. Moving the data bytes is the job of a downstream agent.

When a page is not mapped, or a write hits a page without write permission, the request is abandoned at once. The engine records a fault status word and the page-aligned virtual address that failed, and it raises an interrupt. The interrupt stays high until it is acknowledged. Each request ends with a one-cycle completion pulse or a one-cycle error pulse.

Top module: `dvma_xlate`

## Requirements
- R1: After reset the engine is idle with `req_ready` high. No fetch or command is pending, `flt_irq` is low, `flt_addr` is zero and `flt_status` holds only the reserved bit, 0x00800000.
- R2: The entry address is `cfg_base` shifted left by 4, plus four times the window-relative page number. The window size is 16 MB << `cfg_range`, and the window-relative page number is bits [31:12] of the address masked to that window.
- R3: The physical address of a chunk is entry bits [31:8] placed at physical bits [35:12], with the low 12 virtual address bits as the offset. Entry bits 7, 3 and 0 have no effect.
- R4: The first chunk runs from the start address to the end of its page. Middle chunks are 4096 bytes. The last chunk is cut to the remaining byte count. No chunk crosses a page.
- R5: An entry with bit 1 (valid) clear aborts the request. No command is issued for that page or any later one.
- R6: A write to a page whose entry has bit 2 (writable) clear aborts the request. A read from such a page goes ahead normally.
- R7: On a fault, `flt_status` becomes 0xC0820000 for a write or 0xC0860000 for a read (bit 18 marks a read). `flt_addr` becomes the page-aligned virtual address of the failing page.
- R8: A fault sets `flt_irq` in the same cycle as the `xfer_err` pulse. `flt_irq` stays high until a `flt_ack` cycle, which lowers it.
- R9: A zero-length request gives an `xfer_done` pulse in the next cycle and causes no table fetch.
- R10: `mrd_valid` with `mrd_addr` is held stable until accepted. `cmd_valid` with the command fields is held stable until accepted.
- R11: `req_valid` is ignored while a request is in progress. The command stream of the current request is unchanged.
- R12: `xfer_done` pulses for one cycle right after the last command is accepted. `xfer_done` and `xfer_err` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request accepted |
| req_va | input | 32 | Device virtual start address |
| req_len | input | 16 | Byte count |
| req_write | input | 1 | 1 = write, 0 = read |
| cfg_base | input | 32 | Table base value (shifted left by 4) |
| cfg_range | input | 3 | Window size code, 16 MB << code |
| mrd_valid | output | 1 | Entry fetch request |
| mrd_ready | input | 1 | Fetch request accepted |
| mrd_addr | output | 36 | Entry physical address |
| mrd_rvalid | input | 1 | Entry data returned |
| mrd_rdata | input | 32 | Entry data |
| cmd_valid | output | 1 | Physical command present |
| cmd_ready | input | 1 | Command accepted |
| cmd_pa | output | 36 | Physical address of chunk |
| cmd_len | output | 16 | Chunk length in bytes |
| cmd_write | output | 1 | Chunk direction |
| xfer_done | output | 1 | Request completed pulse |
| xfer_err | output | 1 | Request aborted pulse |
| flt_status | output | 32 | Fault status word |
| flt_addr | output | 32 | Failing page virtual address |
| flt_irq | output | 1 | Fault interrupt |
| flt_ack | input | 1 | Lowers the fault interrupt |

## Verification
The bench builds the engine with its default parameters: 32-bit virtual addresses, a 36-bit physical address, a 16-bit length, 12 page bits and a 24-bit minimum window. With these values the bench can run transfers that span four pages, use an entry with an all-ones page number that drives physical bit 35, and use a single-byte chunk at offset 0xFFF. The same values also make the 64 MB and 2 GB windows reachable, so bench cases hit both the mask and the unmapped high index. The command-accept line stalls on a fixed pattern, which lets the bench test that fields stay stable and that stray requests are ignored while a transfer is busy.

// File: rtl/dvma_pkg.sv
package dvma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2,
    ST_ISSUE = 2'd3
  } dvma_state_e;

  localparam logic [31:0] FS_ERR   = 32'h8000_0000;
  localparam logic [31:0] FS_LATE  = 32'h4000_0000;
  localparam logic [31:0] FS_RSVD  = 32'h0080_0000;
  localparam logic [31:0] FS_READ  = 32'h0004_0000;
  localparam logic [31:0] FS_AVAL  = 32'h0002_0000;

  localparam int ENT_VALID_BIT = 1;
  localparam int ENT_WR_BIT    = 2;
  localparam int ENT_PPN_LSB   = 8;
endpackage

// File: rtl/dvma_addr_gen.sv
module dvma_addr_gen #(
  parameter int VA_W     = 32,
  parameter int PA_W     = 36,
  parameter int LEN_W    = 16,
  parameter int PG_BITS  = 12,
  parameter int RANGE_W  = 3,
  parameter int WIN_BITS = 24
) (
  input  logic [VA_W-1:0]    va,
  input  logic [LEN_W-1:0]   rem,
  input  logic [31:0]        base,
  input  logic [RANGE_W-1:0] range_sel,
  input  logic [31:dvma_pkg::ENT_PPN_LSB] ppn,
  output logic [PA_W-1:0]    ent_addr,
  output logic [PA_W-1:0]    phys,
  output logic [LEN_W-1:0]   chunk,
  output logic [VA_W-1:0]    page_va
);
  localparam int PGN_W   = VA_W - PG_BITS;
  localparam int PG_SIZE = 1 << PG_BITS;
  localparam int WIN_SH  = WIN_BITS - PG_BITS;

  logic [PGN_W-1:0] win_mask;
  logic [PGN_W-1:0] rel_page;
  logic [LEN_W-1:0] to_end;

  always_comb begin
    win_mask = ({{(PGN_W-1){1'b0}}, 1'b1} << (WIN_SH + int'(range_sel))) - 1'b1;
    rel_page = va[VA_W-1:PG_BITS] & win_mask;
    ent_addr = (PA_W'(base) << 4) + PA_W'({rel_page, 2'b00});
    phys     = (PA_W'(ppn) << PG_BITS) | PA_W'(va[PG_BITS-1:0]);
    to_end   = LEN_W'(PG_SIZE) - LEN_W'(va[PG_BITS-1:0]);
    chunk    = (rem < to_end) ? rem : to_end;
    page_va  = {va[VA_W-1:PG_BITS], {PG_BITS{1'b0}}};
  end
endmodule

// File: rtl/dvma_ent_check.sv
module dvma_ent_check (
  input  logic        ent_valid,
  input  logic        ent_wr,
  input  logic        is_write,
  output logic        fault,
  output logic [31:0] status
);
  import dvma_pkg::*;
  always_comb begin
    fault  = !ent_valid || (is_write && !ent_wr);
    status = FS_ERR | FS_LATE | FS_RSVD | FS_AVAL | (is_write ? 32'h0 : FS_READ);
  end
endmodule

// File: rtl/dvma_fault_regs.sv
module dvma_fault_regs #(
  parameter int VA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic [31:0]     status_in,
  input  logic [VA_W-1:0] addr_in,
  input  logic            ack,
  output logic [31:0]     status,
  output logic [VA_W-1:0] addr,
  output logic            irq
);
  logic irq_d;

  always_comb begin
    irq_d = irq;
    if (ack)     irq_d = 1'b0;
    if (capture) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= dvma_pkg::FS_RSVD;
      addr   <= '0;
      irq    <= 1'b0;
    end else begin
      irq <= irq_d;
      if (capture) begin
        status <= status_in;
        addr   <= addr_in;
      end
    end
  end

  // R8: an acknowledge with no new fault lowers the interrupt
  assert_ack_lowers_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !capture) |=> !irq);
endmodule

// File: rtl/dvma_xlate.sv
module dvma_xlate #(
  parameter int VA_W     = 32,
  parameter int PA_W     = 36,
  parameter int LEN_W    = 16,
  parameter int PG_BITS  = 12,
  parameter int RANGE_W  = 3,
  parameter int WIN_BITS = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_va,
  input  logic [LEN_W-1:0]   req_len,
  input  logic               req_write,
  input  logic [31:0]        cfg_base,
  input  logic [RANGE_W-1:0] cfg_range,
  output logic               mrd_valid,
  input  logic               mrd_ready,
  output logic [PA_W-1:0]    mrd_addr,
  input  logic               mrd_rvalid,
  input  logic [31:0]        mrd_rdata,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [PA_W-1:0]    cmd_pa,
  output logic [LEN_W-1:0]   cmd_len,
  output logic               cmd_write,
  output logic               xfer_done,
  output logic               xfer_err,
  output logic [31:0]        flt_status,
  output logic [VA_W-1:0]    flt_addr,
  output logic               flt_irq,
  input  logic               flt_ack
);
  import dvma_pkg::*;
  localparam int PG_SIZE = 1 << PG_BITS;

  dvma_state_e      state_q, state_d;
  logic [VA_W-1:0]  va_q, va_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic             wr_q, wr_d;
  logic [PA_W-1:0]  pa_q, pa_d;
  logic [LEN_W-1:0] chunk_q, chunk_d;
  logic             done_q, done_d, err_q, err_d;
  logic             capture;

  logic [PA_W-1:0]  ent_addr_w, phys_w;
  logic [LEN_W-1:0] chunk_w;
  logic [VA_W-1:0]  page_va_w;
  logic             fault_w;
  logic [31:0]      fstat_w;

  dvma_addr_gen #(
    .VA_W(VA_W), .PA_W(PA_W), .LEN_W(LEN_W), .PG_BITS(PG_BITS),
    .RANGE_W(RANGE_W), .WIN_BITS(WIN_BITS)
  ) u_agen (
    .va(va_q), .rem(rem_q), .base(cfg_base), .range_sel(cfg_range),
    .ppn(mrd_rdata[31:ENT_PPN_LSB]), .ent_addr(ent_addr_w), .phys(phys_w),
    .chunk(chunk_w), .page_va(page_va_w)
  );

  dvma_ent_check u_chk (
    .ent_valid(mrd_rdata[ENT_VALID_BIT]), .ent_wr(mrd_rdata[ENT_WR_BIT]),
    .is_write(wr_q), .fault(fault_w), .status(fstat_w)
  );

  dvma_fault_regs #(.VA_W(VA_W)) u_flt (
    .clk(clk), .rst_n(rst_n), .capture(capture), .status_in(fstat_w),
    .addr_in(page_va_w), .ack(flt_ack), .status(flt_status),
    .addr(flt_addr), .irq(flt_irq)
  );

  always_comb begin
    state_d = state_q;
    va_d    = va_q;
    rem_d   = rem_q;
    wr_d    = wr_q;
    pa_d    = pa_q;
    chunk_d = chunk_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    capture = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_len == '0) begin
            done_d = 1'b1;
          end else begin
            va_d    = req_va;
            rem_d   = req_len;
            wr_d    = req_write;
            state_d = ST_FETCH;
          end
        end
      end
      ST_FETCH: begin
        if (mrd_ready) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (mrd_rvalid) begin
          if (fault_w) begin
            capture = 1'b1;
            err_d   = 1'b1;
            state_d = ST_IDLE;
          end else begin
            pa_d    = phys_w;
            chunk_d = chunk_w;
            state_d = ST_ISSUE;
          end
        end
      end
      ST_ISSUE: begin
        if (cmd_ready) begin
          va_d  = va_q + VA_W'(chunk_q);
          rem_d = rem_q - chunk_q;
          if (rem_q == chunk_q) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            state_d = ST_FETCH;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      rem_q   <= '0;
      wr_q    <= 1'b0;
      pa_q    <= '0;
      chunk_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      va_q    <= va_d;
      rem_q   <= rem_d;
      wr_q    <= wr_d;
      pa_q    <= pa_d;
      chunk_q <= chunk_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign mrd_valid = (state_q == ST_FETCH);
  assign mrd_addr  = ent_addr_w;
  assign cmd_valid = (state_q == ST_ISSUE);
  assign cmd_pa    = pa_q;
  assign cmd_len   = chunk_q;
  assign cmd_write = wr_q;
  assign xfer_done = done_q;
  assign xfer_err  = err_q;

  // R10: fetch request held until taken
  assert_fetch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mrd_valid && !mrd_ready) |=> (mrd_valid && $stable(mrd_addr)));
  // R10: command held until taken
  assert_cmd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_pa) &&
                                   $stable(cmd_len) && $stable(cmd_write)));
  // R4: no command is empty or crosses a page
  assert_chunk_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_len != '0) &&
                  ((int'(cmd_pa[PG_BITS-1:0]) + int'(cmd_len)) <= PG_SIZE));
  // R9: zero length completes next cycle
  assert_zero_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_len == '0) |=> (xfer_done && req_ready));
  // R8: fault pulse comes with interrupt and error status
  assert_err_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err |-> (flt_irq && flt_status[31] && flt_status[17]));
  // R12: completion and abort are exclusive
  assert_end_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_done && xfer_err));
endmodule

// File: tb/dvma_xlate_test.sv
`timescale 1ns/1ps
module dvma_xlate_test;
  logic        clk, rst_n;
  logic        req_valid, req_ready, req_write;
  logic [31:0] req_va;
  logic [15:0] req_len;
  logic [31:0] cfg_base;
  logic [2:0]  cfg_range;
  logic        mrd_valid, mrd_ready, mrd_rvalid;
  logic [35:0] mrd_addr;
  logic [31:0] mrd_rdata;
  logic        cmd_valid, cmd_ready, cmd_write;
  logic [35:0] cmd_pa;
  logic [15:0] cmd_len;
  logic        xfer_done, xfer_err, flt_irq, flt_ack;
  logic [31:0] flt_status, flt_addr;

  dvma_xlate uut (.*);

  typedef struct { logic [35:0] pa; logic [15:0] len; logic wr; } cmd_t;
  typedef struct { bit is_err; logic [31:0] st; logic [31:0] ad; } end_t;

  cmd_t        cq[$];
  logic [35:0] fq[$];
  end_t        eq[$];
  logic [31:0] tbl [logic [35:0]];

  int vectors = 0, errors = 0, cyc = 0, ends_seen = 0;
  bit pending = 0;
  logic [31:0] pend_data;
  bit done_all = 0;

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ent(input logic [23:0] ppn, input bit wr, input bit v, input logic [7:0] junk);
    return {ppn, 8'h0} | {24'h0, junk & 8'hB9} | (wr ? 32'h4 : 32'h0) | (v ? 32'h2 : 32'h0);
  endfunction

  function automatic logic [35:0] ent_addr_of(input logic [31:0] va);
    logic [31:0] mask;
    mask = (32'h0100_0000 << cfg_range) - 32'h1;
    return ({4'h0, cfg_base} << 4) + {4'h0, ((va & mask) >> 10) & 32'hFFFF_FFFC};
  endfunction

  // Monitor and memory model
  always @(negedge clk) begin
    cyc++;
    cmd_ready = (cyc % 3) != 1;
    mrd_rvalid = pending;
    mrd_rdata  = pending ? pend_data : 32'h0;
    pending = 0;
    if (rst_n && mrd_valid && mrd_ready) begin
      if (fq.size() == 0) chk("R9 unexpected fetch", {28'h0, mrd_addr}, 64'h0);
      else chk("R2 entry address", {28'h0, mrd_addr}, {28'h0, fq.pop_front()});
      pend_data = tbl.exists(mrd_addr) ? tbl[mrd_addr] : 32'h0;
      pending = 1;
    end
    if (rst_n && cmd_valid && cmd_ready) begin
      if (cq.size() == 0) chk("R5 unexpected command", {28'h0, cmd_pa}, 64'h0);
      else begin
        cmd_t e;
        e = cq.pop_front();
        chk("R3 physical address", {28'h0, cmd_pa}, {28'h0, e.pa});
        chk("R4 chunk length", {48'h0, cmd_len}, {48'h0, e.len});
        chk("R6 command direction", {63'h0, cmd_write}, {63'h0, e.wr});
      end
    end
    if (rst_n && (xfer_done || xfer_err)) begin
      if (eq.size() == 0) chk("R12 unexpected end", 64'h1, 64'h0);
      else begin
        end_t x;
        x = eq.pop_front();
        chk("R12 end kind", {63'h0, xfer_err}, {63'h0, x.is_err});
        chk("R12 pending commands", cq.size(), 0);
        if (x.is_err) begin
          chk("R7 fault status", {32'h0, flt_status}, {32'h0, x.st});
          chk("R7 fault address", {32'h0, flt_addr}, {32'h0, x.ad});
          chk("R8 irq raised", {63'h0, flt_irq}, 64'h1);
        end
      end
      ends_seen++;
    end
  end

  task automatic do_req(input logic [31:0] va, input logic [15:0] len, input bit wr, input bit poke);
    logic [31:0] a = va;
    int rem = len;
    int prev;
    while (rem > 0) begin
      logic [35:0] ea;
      logic [31:0] e;
      int l;
      ea = ent_addr_of(a);
      e  = tbl.exists(ea) ? tbl[ea] : 32'h0;
      fq.push_back(ea);
      l = 4096 - int'(a[11:0]);
      if (l > rem) l = rem;
      if (!e[1] || (wr && !e[2])) begin
        eq.push_back('{1'b1, 32'hC082_0000 | (wr ? 32'h0 : 32'h0004_0000), {a[31:12], 12'h0}});
        rem = 0;
      end else begin
        cq.push_back('{{e[31:8], a[11:0]}, 16'(l), wr});
        rem -= l;
        a += 32'(l);
        if (rem == 0) eq.push_back('{1'b0, 32'h0, 32'h0});
      end
    end
    if (len == 0) eq.push_back('{1'b0, 32'h0, 32'h0});
    prev = ends_seen;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_va = va; req_len = len; req_write = wr; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    if (poke) begin
      @(negedge clk);
      // R11: stray request while busy must be ignored
      req_va = 32'hFF00_0000; req_len = 16'h40; req_write = 1; req_valid = 1;
      @(negedge clk); @(negedge clk);
      req_valid = 0;
    end
    while (ends_seen == prev) @(negedge clk);
    chk("R12 queues drained", fq.size() + cq.size() + eq.size(), 0);
  endtask

  task automatic ack_irq;
    @(negedge clk);
    chk("R8 irq held until ack", {63'h0, flt_irq}, 64'h1);
    flt_ack = 1;
    @(negedge clk);
    flt_ack = 0;
    chk("R8 irq cleared by ack", {63'h0, flt_irq}, 64'h0);
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_va = 0; req_len = 0; req_write = 0;
    cfg_base = 32'h0010_0000; cfg_range = 3'd0; mrd_ready = 1;
    mrd_rvalid = 0; mrd_rdata = 0; cmd_ready = 0; flt_ack = 0;
    tbl[36'h0100_0000] = ent(24'h0A1000, 1, 1, 8'h80);
    tbl[36'h0100_0004] = ent(24'hFFFFFF, 1, 1, 8'h01);
    tbl[36'h0100_0008] = ent(24'h000123, 1, 1, 8'h81);
    tbl[36'h0100_000C] = ent(24'h0A2000, 0, 1, 8'h00);
    tbl[36'h0100_0014] = ent(24'h0B0005, 1, 1, 8'h00);
    tbl[36'h0100_048C] = ent(24'h0C0DE0, 0, 1, 8'h80);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 req_ready", {63'h0, req_ready}, 64'h1);
    chk("R1 mrd_valid", {63'h0, mrd_valid}, 64'h0);
    chk("R1 cmd_valid", {63'h0, cmd_valid}, 64'h0);
    chk("R1 irq", {63'h0, flt_irq}, 64'h0);
    chk("R1 status", {32'h0, flt_status}, 64'h0080_0000);
    chk("R1 addr", {32'h0, flt_addr}, 64'h0);
    rst_n = 1;
    @(negedge clk);
    do_req(32'hFF00_0F00, 16'h2200, 0, 0);   // R4 four chunks, R3 top PPN
    do_req(32'hFF00_0010, 16'h0020, 1, 0);   // R6 write to writable page
    do_req(32'hFF00_2800, 16'h1000, 1, 0);   // R6 write fault on second page
    ack_irq();
    do_req(32'hFF00_4004, 16'h0008, 0, 0);   // R5 invalid entry read fault
    ack_irq();
    do_req(32'hFF00_3010, 16'h0100, 0, 0);   // R6 read of read-only page
    do_req(32'hFF00_1234, 16'h0000, 0, 0);   // R9 zero length
    do_req(32'hFF00_5000, 16'h1000, 0, 0);   // R4 exact single page
    do_req(32'hFF00_5FFF, 16'h0001, 1, 0);   // R4 one byte at page end
    do_req(32'hFF00_0F00, 16'h2200, 0, 1);   // R11 stray request ignored
    cfg_range = 3'd2;
    do_req(32'hFC12_3456, 16'h0010, 0, 0);   // R2 64 MB window
    cfg_range = 3'd7;
    do_req(32'h8000_5000, 16'h0010, 0, 0);   // R2 2 GB window
    do_req(32'hFF00_5000, 16'h0010, 1, 0);   // R5 unmapped high index
    ack_irq();
    done_all = 1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done_all) break;
    end
    if (!done_all) begin
      vectors++; errors++;
      $display("FAIL watchdog expired actual=hung expected=complete");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule